// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial-memory bus engine and a byte-wide RAM array. It gathers the data bytes of a byte or page write into a small page buffer. It does not touch the array until the bus engine signals the end of the transfer. At that point it starts a self-timed program cycle of fixed length and copies the buffered bytes into the RAM. While the cycle runs, a busy flag tells the bus engine to stop answering the host.

The first byte loaded in a transfer sets the page (the upper address bits) and the starting offset within the page. Each later byte goes to the next offset. Only the low offset bits advance, so the offset wraps inside the page and can overwrite bytes loaded earlier. A write-protect input is sampled when the stop strobe arrives. If it is high, the gathered bytes are discarded and no cycle starts. A stop that arrives with nothing loaded, such as the stop after an address-only write that sets up a read, is also dropped.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low.
- R2: A `load_i` pulse while not busy stores `load_data_i`. When the buffer is empty, the upper bits of `load_addr_i` become the page base and its low 2 bits become the starting offset.
- R3: While the buffer already holds bytes, each further load goes to the previous offset plus one, modulo 4. `load_addr_i` is ignored and the page base does not change.
- R4: When more than 4 bytes are loaded before the stop, the offset wraps and the newest byte replaces the earlier one at that offset.
- R5: No RAM write happens before a stop. Busy rises only in the cycle after an accepted `stop_i` pulse.
- R6: An accepted stop (not busy, at least one byte loaded, `wr_protect_i` low) holds `busy_o` high for exactly `WRITE_CYCLES` clock cycles.
- R7: In busy cycle k (k = 0..3, where k = 0 is the first cycle with busy high), offset k is written to address {page base, k} if that offset was loaded. Offsets that were not loaded get no write.
- R8: If `wr_protect_i` is high in the cycle of the stop pulse, busy stays low, no write occurs and the buffered bytes are discarded.
- R9: A stop with an empty buffer starts no cycle.
- R10: Load and stop pulses that arrive while busy is high have no effect on the buffer or on the cycle length.
- R11: A transfer with a single data byte writes exactly that one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe: a data byte has been received |
| load_addr_i | input | ADDR_W | Word address that goes with the strobe (used on the first byte only) |
| load_data_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | One-cycle strobe: the bus transfer has ended |
| wr_protect_i | input | 1 | High disables all writes; sampled with `stop_i` |
| busy_o | output | 1 | Program cycle in progress; the bus engine must not respond |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | ADDR_W | RAM write address |
| mem_wdata_o | output | DATA_W | RAM write data |

## Verification
The bench builds the block with `WRITE_CYCLES` = 12, while the page size stays at 4 bytes and the address at 8 bits. The short cycle lets the bench measure the exact busy length and see the per-offset write order against the busy-cycle index. It also leaves room to inject loads and stops in the middle of a cycle and to run many transfers in a short run. Wrap-around, a mid-page start, a discarded protected transfer and an empty stop are each driven as their own scenario.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int unsigned PCC_ADDR_W       = 8;
  localparam int unsigned PCC_DATA_W       = 8;
  localparam int unsigned PCC_PAGE_BYTES   = 4;
  // 5 ms at 125 MHz
  localparam int unsigned PCC_WRITE_CYCLES = 625000;
endpackage

// File: rtl/pcc_page_buf.sv
module pcc_page_buf #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 4,
  localparam int unsigned SLOT_W    = $clog2(PAGE_BYTES),
  localparam int unsigned BASE_W    = ADDR_W - SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              busy_i,
  input  logic              clear_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [BASE_W-1:0] base_o,
  output logic              any_valid_o
);

  logic [PAGE_BYTES-1:0][DATA_W-1:0] data_q;
  logic [PAGE_BYTES-1:0]             valid_q;
  logic [BASE_W-1:0]                 base_q;
  logic [SLOT_W-1:0]                 ptr_q;
  logic [SLOT_W-1:0]                 wr_slot;
  logic                              any_valid;

  assign any_valid = |valid_q;
  // first byte of a transfer picks its own offset, later ones follow the pointer
  assign wr_slot   = any_valid ? ptr_q : load_addr_i[SLOT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= '0;
      base_q  <= '0;
      ptr_q   <= '0;
    end else if (clear_i) begin
      valid_q <= '0;
    end else if (load_i && !busy_i) begin
      if (!any_valid) base_q <= load_addr_i[ADDR_W-1:SLOT_W];
      data_q[wr_slot]  <= load_data_i;
      valid_q[wr_slot] <= 1'b1;
      ptr_q            <= wr_slot + 1'b1;
    end
  end

  assign rd_data_o   = data_q[rd_slot_i];
  assign rd_valid_o  = valid_q[rd_slot_i];
  assign base_o      = base_q;
  assign any_valid_o = any_valid;

  assert_busy_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !clear_i |=> $stable(valid_q) && $stable(data_q));

  assert_base_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !busy_i && !clear_i && any_valid |=> $stable(base_q));

endmodule

// File: rtl/pcc_cycle_timer.sv
module pcc_cycle_timer #(
  parameter int unsigned PAGE_BYTES   = 4,
  parameter int unsigned WRITE_CYCLES = 625000,
  localparam int unsigned SLOT_W      = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              slot_act_o,
  output logic [SLOT_W-1:0] slot_o
);

  localparam logic [SLOT_W:0]  SlotEnd = (SLOT_W+1)'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] CntInit = CNT_W'(WRITE_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SLOT_W:0]  slot_q;

  assign done_o     = busy_q && (cnt_q == '0);
  assign slot_act_o = busy_q && (slot_q < SlotEnd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CntInit;
        slot_q <= '0;
      end
    end else begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      if (slot_q < SlotEnd) slot_q <= slot_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign slot_o = slot_q[SLOT_W-1:0];

  assert_full_length_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == '0);

  assert_start_taken_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_q && slot_q == '0);

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pcc_pkg::*;
#(
  parameter int unsigned ADDR_W       = PCC_ADDR_W,
  parameter int unsigned DATA_W       = PCC_DATA_W,
  parameter int unsigned PAGE_BYTES   = PCC_PAGE_BYTES,
  parameter int unsigned WRITE_CYCLES = PCC_WRITE_CYCLES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              stop_i,
  input  logic              wr_protect_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);

  localparam int unsigned SLOT_W = $clog2(PAGE_BYTES);
  localparam int unsigned BASE_W = ADDR_W - SLOT_W;

  logic              busy, done, slot_act, any_valid, rd_valid;
  logic              stop_ok, start, discard, clear;
  logic [SLOT_W-1:0] slot;
  logic [BASE_W-1:0] base;
  logic [DATA_W-1:0] rd_data;

  assign stop_ok = stop_i && !busy;
  assign start   = stop_ok && any_valid && !wr_protect_i;
  assign discard = stop_ok && (wr_protect_i || !any_valid);
  assign clear   = discard || done;

  pcc_page_buf #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_addr_i(load_addr_i),
    .load_data_i(load_data_i),
    .busy_i     (busy),
    .clear_i    (clear),
    .rd_slot_i  (slot),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid),
    .base_o     (base),
    .any_valid_o(any_valid)
  );

  pcc_cycle_timer #(
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .busy_o    (busy),
    .done_o    (done),
    .slot_act_o(slot_act),
    .slot_o    (slot)
  );

  assign busy_o      = busy;
  assign mem_we_o    = slot_act && rd_valid;
  assign mem_addr_o  = {base, slot};
  assign mem_wdata_o = rd_data;

  assert_we_in_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  assert_rise_after_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  assert_protect_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !busy_o && wr_protect_i |=> !busy_o && !mem_we_o);

  assert_empty_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !busy_o && !any_valid |=> !busy_o);

endmodule

// File: tb/page_commit_ctrl_tb_top.sv
module page_commit_ctrl_tb_top;
  localparam int W = 12;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0, stop_i = 1'b0, wr_protect_i = 1'b0;
  logic [7:0] load_addr_i = '0, load_data_i = '0;
  logic       busy_o, mem_we_o;
  logic [7:0] mem_addr_o, mem_wdata_o;

  int checks = 0, failures = 0;
  logic [7:0] log_addr [0:15];
  logic [7:0] log_data [0:15];
  int         log_cyc  [0:15];
  int         n_wr = 0;
  int         busy_idx = 0;

  always #4 clk = ~clk;

  page_commit_ctrl #(.WRITE_CYCLES(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .load_addr_i(load_addr_i),
    .load_data_i(load_data_i), .stop_i(stop_i), .wr_protect_i(wr_protect_i),
    .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (mem_we_o && n_wr < 16) begin
        log_addr[n_wr] = mem_addr_o;
        log_data[n_wr] = mem_wdata_o;
        log_cyc[n_wr]  = busy_o ? busy_idx : -1;
        n_wr = n_wr + 1;
      end
      busy_idx = busy_o ? busy_idx + 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); load_i = 1'b1; load_addr_i = a; load_data_i = d;
    @(negedge clk); load_i = 1'b0;
  endtask

  task automatic stop(input logic prot);
    @(negedge clk); stop_i = 1'b1; wr_protect_i = prot;
    @(negedge clk); stop_i = 1'b0; wr_protect_i = 1'b0;
  endtask

  task automatic measure_busy(output int len);
    len = 0;
    while (busy_o && len < 1000) begin len++; @(negedge clk); end
  endtask

  task automatic chk_wr(input int i, input string req, input logic [7:0] a,
                        input logic [7:0] d, input int cyc);
    chk(log_addr[i] == a, req, "write addr", log_addr[i], a);
    chk(log_data[i] == d, req, "write data", log_data[i], d);
    chk(log_cyc[i] == cyc, req, "write busy cycle", log_cyc[i], cyc);
  endtask

  task automatic t_reset;
    chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    chk(mem_we_o == 1'b0, "R1", "we after reset", mem_we_o, 0);
  endtask

  task automatic t_single;
    int len;
    n_wr = 0;
    load(8'h45, 8'hA1);
    repeat (3) @(negedge clk);
    chk(n_wr == 0 && !busy_o, "R5", "writes before stop", n_wr, 0);
    stop(1'b0);
    measure_busy(len);
    chk(len == W, "R6", "busy length", len, W);
    chk(n_wr == 1, "R11", "single byte write count", n_wr, 1);
    chk_wr(0, "R11", 8'h45, 8'hA1, 1);
  endtask

  task automatic t_page;
    int len;
    n_wr = 0;
    for (int i = 0; i < 4; i++) load(8'h80 + 8'(i), 8'h10 + 8'(i));
    stop(1'b0);
    measure_busy(len);
    chk(len == W, "R6", "busy length page", len, W);
    chk(n_wr == 4, "R7", "page write count", n_wr, 4);
    for (int i = 0; i < 4; i++) chk_wr(i, "R7", 8'h80 + 8'(i), 8'h10 + 8'(i), i);
  endtask

  task automatic t_midpage;
    int len;
    n_wr = 0;
    load(8'h1E, 8'hC0);
    load(8'h77, 8'hC1);   // address ignored after first byte
    load(8'h00, 8'hC2);
    stop(1'b0);
    measure_busy(len);
    chk(n_wr == 3, "R3", "mid-page write count", n_wr, 3);
    chk_wr(0, "R3", 8'h1C, 8'hC2, 0);
    chk_wr(1, "R2", 8'h1E, 8'hC0, 2);
    chk_wr(2, "R3", 8'h1F, 8'hC1, 3);
  endtask

  task automatic t_wrap;
    int len;
    n_wr = 0;
    for (int i = 0; i < 6; i++) load(8'h40, 8'hD0 + 8'(i));
    stop(1'b0);
    measure_busy(len);
    chk(n_wr == 4, "R4", "wrap write count", n_wr, 4);
    chk_wr(0, "R4", 8'h40, 8'hD4, 0);
    chk_wr(1, "R4", 8'h41, 8'hD5, 1);
    chk_wr(2, "R4", 8'h42, 8'hD2, 2);
    chk_wr(3, "R4", 8'h43, 8'hD3, 3);
  endtask

  task automatic t_protect;
    int len;
    bit seen;
    n_wr = 0;
    seen = 0;
    load(8'h61, 8'hAA);
    stop(1'b1);
    for (int i = 0; i < W + 2; i++) begin
      if (busy_o) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R8", "busy with protect", seen, 0);
    chk(n_wr == 0, "R8", "writes with protect", n_wr, 0);
    load(8'h72, 8'hBB);
    stop(1'b0);
    measure_busy(len);
    chk(n_wr == 1, "R8", "discarded byte not written", n_wr, 1);
    chk_wr(0, "R8", 8'h72, 8'hBB, 2);
  endtask

  task automatic t_empty;
    bit seen;
    n_wr = 0;
    seen = 0;
    stop(1'b0);
    for (int i = 0; i < 4; i++) begin
      if (busy_o) seen = 1;
      @(negedge clk);
    end
    chk(!seen && n_wr == 0, "R9", "empty stop started cycle", seen, 0);
  endtask

  task automatic t_busy_ignore;
    int len;
    bit seen;
    n_wr = 0;
    seen = 0;
    load(8'h10, 8'h11);
    stop(1'b0);
    len = 0;
    while (busy_o && len < 1000) begin
      len++;
      if (len == 2) begin load_i = 1'b1; load_addr_i = 8'h13; load_data_i = 8'h99; end
      else load_i = 1'b0;
      stop_i = (len == 4 || len == W - 1);
      @(negedge clk);
    end
    load_i = 1'b0; stop_i = 1'b0;
    chk(len == W, "R10", "busy length with strobes", len, W);
    chk(n_wr == 1, "R10", "write count with strobes", n_wr, 1);
    stop(1'b0);
    for (int i = 0; i < 4; i++) begin
      if (busy_o) seen = 1;
      @(negedge clk);
    end
    chk(!seen && n_wr == 1, "R10", "load during busy kept", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_page;
    t_midpage;
    t_wrap;
    t_protect;
    t_empty;
    t_busy_ignore;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule